// File: doc/BRIEF.md
# Burst Address Sequencer

This block is the address-phase engine of a bus master on a pipelined single-master system bus. A request gives a start address, a transfer size, a burst kind, a read/write flag and, for open-length bursts, a beat count. The block then drives the transfer type, the address and the burst controls for every beat. It moves to the next beat each time the slave signals ready. Four kinds of burst are supported: a single transfer, an open-length incrementing burst, fixed incrementing bursts of 4, 8 or 16 beats, and wrapping bursts of 4, 8 or 16 beats.

The master can insert BUSY cycles between beats through a stall input. A slave response that is not OKAY, seen while ready is low, makes the block drop the rest of the burst and return to IDLE. A request is taken only while the bus shows IDLE and ready is high. If the request is valid, the block starts the burst at once. If it is invalid, the block flags it and leaves the bus idle. A request that arrives at any other time waits, with neither flag raised.

Top module: `burst_addr_seq`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next cycle shows `bus_trans` = IDLE (code 0) and `bus_addr` = 0.
- R2: When `bus_trans` is IDLE, `bus_ready` is 1, `req_valid` is 1 and the request is valid, `req_accept` is 1 in that cycle. In the next cycle `bus_trans` is NONSEQ (code 2), and `bus_addr`, `bus_burst`, `bus_size` and `bus_write` equal the request fields.
- R3: Every beat after the first shows SEQ (code 3). A cycle showing IDLE is followed only by IDLE or NONSEQ, and the stall input has no effect while the bus is idle.
- R4: Burst codes are 0 single, 1 open incrementing, 2/3 wrap/incr 4 beats, 4/5 wrap/incr 8 beats, and 6/7 wrap/incr 16 beats. Bit 0 set with bits [2:1] nonzero means incrementing. A fixed burst issues exactly its nominal number of beats. An open burst issues `req_len` beats, and a length of 0 counts as 1. After the last beat is accepted, the bus shows IDLE.
- R5: In an incrementing burst, each accepted beat that is not the last adds 2^`bus_size` bytes to the address. Size codes are 0 byte, 1 halfword and 2 word.
- R6: In a wrapping burst, address bits at and above log2(beats) + size stay fixed. The bits below advance by 2^size and wrap around within that block.
- R7: While `bus_ready` is 0 and `bus_resp` is OKAY (code 0), every bus output holds its value.
- R8: If `stall_req` is 1 when a beat other than the last is accepted, the next cycle shows BUSY (code 1) with the next beat's address. BUSY repeats while `stall_req` stays 1, with address and control held. The burst then resumes with SEQ at that same address. A single transfer or a last beat never leads to BUSY.
- R9: A non-OKAY `bus_resp` seen while `bus_ready` is 0 makes the next cycle IDLE, and the remaining beats are never issued.
- R10: A request is rejected if any of these holds: its size code is above 2; its address is not a multiple of 2^size; or it is incrementing and its last beat would lie in a different 1 KB page from its first. A rejected request raises `req_error` (and not `req_accept`) in the offered cycle, and the bus stays IDLE.
- R11: On every SEQ or BUSY cycle, address bits [AW-1:10] equal those of the previous cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | A burst request is offered |
| req_addr | input | AW | Start address of the request |
| req_size | input | 3 | Transfer size code, bytes = 2^code |
| req_burst | input | 3 | Burst kind code |
| req_write | input | 1 | 1 for a write burst |
| req_len | input | LEN_W | Beat count of an open incrementing burst |
| stall_req | input | 1 | Master asks for BUSY cycles between beats |
| bus_ready | input | 1 | Slave ready; a beat advances when 1 |
| bus_resp | input | 2 | Slave response, 0 is OKAY |
| req_accept | output | 1 | Request taken this cycle |
| req_error | output | 1 | Request rejected this cycle |
| bus_trans | output | 2 | Transfer type: 0 IDLE, 1 BUSY, 2 NONSEQ, 3 SEQ |
| bus_addr | output | AW | Address of the current beat |
| bus_burst | output | 3 | Burst kind of the current burst |
| bus_size | output | 3 | Size code of the current burst |
| bus_write | output | 1 | Direction of the current burst |

## Verification
The assertions check these rules on every cycle: the legal successors of IDLE, holding during wait states, address and control frozen across BUSY, the abort to IDLE after an error, the 1 KB page rule, and the end of a single transfer. Some behaviour only the bench scenarios can show. This covers the actual address sequences of each incrementing and wrapping kind and the exact beat count of each kind. It also covers the rejection cases and a burst that ends exactly on a page's last word.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic [1:0] {
    TR_IDLE   = 2'd0,
    TR_BUSY   = 2'd1,
    TR_NONSEQ = 2'd2,
    TR_SEQ    = 2'd3
  } trans_e;

  localparam logic [2:0] BT_SINGLE = 3'd0;
  localparam logic [2:0] BT_INCR   = 3'd1;
  localparam logic [1:0] RESP_OKAY = 2'd0;
  localparam logic [2:0] SZ_MAX    = 3'd2;
  localparam int         PAGE_BITS = 10;

  // Wrapping kinds have a nonzero length field and bit 0 clear.
  function automatic logic is_wrap(input logic [2:0] bt);
    return (bt[2:1] != 2'd0) && !bt[0];
  endfunction

  // Nominal beats of a fixed kind; the open kind reports 0.
  function automatic int unsigned fixed_beats(input logic [2:0] bt);
    case (bt[2:1])
      2'd0:    return bt[0] ? 0 : 1;
      2'd1:    return 4;
      2'd2:    return 8;
      default: return 16;
    endcase
  endfunction

  // log2 of the beat count of a 4/8/16-beat kind.
  function automatic int unsigned beats_log2(input logic [2:0] bt);
    return 32'(bt[2:1]) + 1;
  endfunction

  // Low address bits that must be clear for a given size code.
  function automatic logic [1:0] align_mask(input logic [2:0] sz);
    case (sz)
      3'd0:    return 2'b00;
      3'd1:    return 2'b01;
      default: return 2'b11;
    endcase
  endfunction

endpackage

// File: rtl/burst_req_check.sv
module burst_req_check
  import burst_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 6,
  parameter int CNT_W = 6
) (
  input  logic [AW-1:0]    addr,
  input  logic [2:0]       size,
  input  logic [2:0]       burst,
  input  logic [LEN_W-1:0] len,
  output logic             reject,
  output logic [CNT_W-1:0] beat_count
);

  logic          bad_size;
  logic          misaligned;
  logic          crosses_page;
  logic [AW-1:0] span;
  logic [AW-1:0] last_addr;

  always_comb begin
    bad_size   = size > SZ_MAX;
    misaligned = |(addr[1:0] & align_mask(size));
    if (burst == BT_INCR)
      beat_count = (len == '0) ? CNT_W'(1) : CNT_W'(len);
    else
      beat_count = CNT_W'(fixed_beats(burst));
    span         = AW'(beat_count - CNT_W'(1)) << size;
    last_addr    = addr + span;
    crosses_page = !is_wrap(burst) &&
                   (last_addr[AW-1:PAGE_BITS] != addr[AW-1:PAGE_BITS]);
    reject       = bad_size | misaligned | crosses_page;
  end

endmodule

// File: rtl/burst_addr_step.sv
module burst_addr_step
  import burst_seq_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic [AW-1:0] addr,
  input  logic [2:0]    size,
  input  logic [2:0]    burst,
  output logic [AW-1:0] next_addr
);

  logic [AW-1:0] step;
  logic [AW-1:0] sum;
  logic [AW-1:0] wrap_mask;
  logic [4:0]    wrap_bits;

  always_comb begin
    step      = AW'(1) << size;
    sum       = addr + step;
    wrap_bits = 5'(beats_log2(burst)) + 5'(size);
    wrap_mask = (AW'(1) << wrap_bits) - AW'(1);
    if (is_wrap(burst))
      next_addr = (addr & ~wrap_mask) | (sum & wrap_mask);
    else
      next_addr = sum;
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [AW-1:0]    req_addr,
  input  logic [2:0]       req_size,
  input  logic [2:0]       req_burst,
  input  logic             req_write,
  input  logic [LEN_W-1:0] req_len,
  input  logic             stall_req,
  input  logic             bus_ready,
  input  logic [1:0]       bus_resp,
  output logic             req_accept,
  output logic             req_error,
  output logic [1:0]       bus_trans,
  output logic [AW-1:0]    bus_addr,
  output logic [2:0]       bus_burst,
  output logic [2:0]       bus_size,
  output logic             bus_write
);

  localparam int CNT_W = (LEN_W > 5) ? LEN_W : 5;

  trans_e           trans_q;
  logic [AW-1:0]    addr_q;
  logic [2:0]       burst_q;
  logic [2:0]       size_q;
  logic             write_q;
  logic [CNT_W-1:0] left_q;

  logic             reject;
  logic [CNT_W-1:0] load_count;
  logic [AW-1:0]    next_addr;

  // Named events, shared with the checker.
  logic take_slot;
  logic start_burst;
  logic beat_accept;
  logic burst_last;
  logic abort_now;
  logic busy_leave;

  burst_req_check #(.AW(AW), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_check (
    .addr       (req_addr),
    .size       (req_size),
    .burst      (req_burst),
    .len        (req_len),
    .reject     (reject),
    .beat_count (load_count)
  );

  burst_addr_step #(.AW(AW)) u_step (
    .addr      (addr_q),
    .size      (size_q),
    .burst     (burst_q),
    .next_addr (next_addr)
  );

  assign take_slot   = (trans_q == TR_IDLE) && bus_ready;
  assign start_burst = take_slot && req_valid && !reject;
  assign req_accept  = start_burst;
  assign req_error   = take_slot && req_valid && reject;
  assign beat_accept = bus_ready && ((trans_q == TR_NONSEQ) || (trans_q == TR_SEQ));
  assign burst_last  = (left_q == CNT_W'(1));
  assign abort_now   = (bus_resp != RESP_OKAY) && !bus_ready;
  assign busy_leave  = bus_ready && (trans_q == TR_BUSY);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      trans_q <= TR_IDLE;
      addr_q  <= '0;
      burst_q <= BT_SINGLE;
      size_q  <= '0;
      write_q <= 1'b0;
      left_q  <= '0;
    end else if (abort_now) begin
      trans_q <= TR_IDLE;
      left_q  <= '0;
    end else if (start_burst) begin
      trans_q <= TR_NONSEQ;
      addr_q  <= req_addr;
      burst_q <= req_burst;
      size_q  <= req_size;
      write_q <= req_write;
      left_q  <= load_count;
    end else if (beat_accept) begin
      if (burst_last) begin
        trans_q <= TR_IDLE;
        left_q  <= '0;
      end else begin
        left_q  <= left_q - CNT_W'(1);
        addr_q  <= next_addr;
        trans_q <= stall_req ? TR_BUSY : TR_SEQ;
      end
    end else if (busy_leave) begin
      trans_q <= stall_req ? TR_BUSY : TR_SEQ;
    end
  end

  assign bus_trans = trans_q;
  assign bus_addr  = addr_q;
  assign bus_burst = burst_q;
  assign bus_size  = size_q;
  assign bus_write = write_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_ready,
  input logic [1:0]    bus_resp,
  input logic          stall_req,
  input logic          req_accept,
  input logic          req_error,
  input logic [1:0]    bus_trans,
  input logic [AW-1:0] bus_addr,
  input logic [2:0]    bus_burst,
  input logic [2:0]    bus_size,
  input logic          bus_write,
  input logic          beat_accept,
  input logic          burst_last
);

  AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> bus_trans == 2'd0); // R1
  AST_START_NONSEQ: assert property (@(posedge clk) disable iff (!rst_n) req_accept |=> bus_trans == 2'd2); // R2
  AST_IDLE_SUCCESSOR: assert property (@(posedge clk) disable iff (!rst_n) bus_trans == 2'd0 |=> (bus_trans == 2'd0 || bus_trans == 2'd2)); // R3
  AST_SINGLE_ENDS: assert property (@(posedge clk) disable iff (!rst_n) (bus_trans == 2'd2 && bus_burst == 3'd0 && bus_ready) |=> bus_trans == 2'd0); // R4
  AST_WAIT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!bus_ready && bus_resp == 2'd0) |=> ($stable(bus_trans) && $stable(bus_addr) && $stable(bus_burst) && $stable(bus_size) && $stable(bus_write))); // R7
  AST_BUSY_INSERT: assert property (@(posedge clk) disable iff (!rst_n) (beat_accept && !burst_last && stall_req) |=> bus_trans == 2'd1); // R8
  AST_BUSY_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) bus_trans == 2'd1 |=> ($stable(bus_addr) && $stable(bus_size) && $stable(bus_write) && $stable(bus_burst))); // R8
  AST_ERROR_ABORT: assert property (@(posedge clk) disable iff (!rst_n) (bus_resp != 2'd0 && !bus_ready) |=> bus_trans == 2'd0); // R9
  AST_REJECT_IDLE: assert property (@(posedge clk) disable iff (!rst_n) req_error |=> bus_trans == 2'd0); // R10
  AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n) (bus_trans == 2'd3 || bus_trans == 2'd1) |-> bus_addr[AW-1:10] == $past(bus_addr[AW-1:10])); // R11

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_ready   (bus_ready),
  .bus_resp    (bus_resp),
  .stall_req   (stall_req),
  .req_accept  (req_accept),
  .req_error   (req_error),
  .bus_trans   (bus_trans),
  .bus_addr    (bus_addr),
  .bus_burst   (bus_burst),
  .bus_size    (bus_size),
  .bus_write   (bus_write),
  .beat_accept (beat_accept),
  .burst_last  (burst_last)
);

// File: tb/tb_burst_addr_seq.sv
module tb_burst_addr_seq;

  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [2:0]  req_size;
  logic [2:0]  req_burst;
  logic        req_write;
  logic [5:0]  req_len;
  logic        stall_req;
  logic        bus_ready;
  logic [1:0]  bus_resp;
  logic        req_accept;
  logic        req_error;
  logic [1:0]  bus_trans;
  logic [31:0] bus_addr;
  logic [2:0]  bus_burst;
  logic [2:0]  bus_size;
  logic        bus_write;

  int n_chk = 0;
  int n_bad = 0;

  always #(CLK_P/2) clk = ~clk;

  burst_addr_seq dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_size(req_size), .req_burst(req_burst), .req_write(req_write),
    .req_len(req_len), .stall_req(stall_req), .bus_ready(bus_ready),
    .bus_resp(bus_resp), .req_accept(req_accept), .req_error(req_error),
    .bus_trans(bus_trans), .bus_addr(bus_addr), .bus_burst(bus_burst),
    .bus_size(bus_size), .bus_write(bus_write)
  );

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", what, act, exp);
    end
  endtask

  // Beat count per burst code (R4).
  function automatic int nbeats(input logic [2:0] bt, input int ln);
    case (bt)
      3'd0:       return 1;
      3'd1:       return (ln == 0) ? 1 : ln;
      3'd2, 3'd3: return 4;
      3'd4, 3'd5: return 8;
      default:    return 16;
    endcase
  endfunction

  // Next beat address, restated as modular arithmetic inside the wrap block (R5, R6).
  function automatic logic [31:0] bump(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] bt);
    logic [31:0] bytes;
    logic [31:0] blk;
    logic [31:0] base;
    bytes = 32'd1 << sz;
    if (bt != 3'd0 && bt[0] == 1'b0) begin
      blk  = bytes * 32'(nbeats(bt, 0));
      base = a - (a % blk);
      return base + ((a - base + bytes) % blk);
    end
    return a + bytes;
  endfunction

  task automatic check_beat(input string what, input logic [1:0] tr, input logic [31:0] a,
                            input logic [2:0] sz, input logic [2:0] bt, input logic w);
    chk({what, " trans"}, 32'(bus_trans), 32'(tr));
    chk({what, " addr"}, bus_addr, a);
    chk({what, " ctrl"}, {25'd0, bus_burst, bus_size, bus_write}, {25'd0, bt, sz, w});
  endtask

  task automatic start_req(input logic [31:0] a, input logic [2:0] sz, input logic [2:0] bt,
                           input logic w, input logic [5:0] ln);
    @(negedge clk);
    req_addr = a; req_size = sz; req_burst = bt; req_write = w; req_len = ln;
    req_valid = 1'b1;
    #1;
    chk("R2 accept", 32'(req_accept), 32'd1);
    chk("R10 no error on valid request", 32'(req_error), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Runs a full burst; stall_at/wait_at pick the beat after which BUSY or a wait state is inserted.
  task automatic run_burst(input string tag, input logic [31:0] a, input logic [2:0] sz,
                           input logic [2:0] bt, input logic w, input logic [5:0] ln,
                           input int stall_at, input int wait_at);
    int n;
    logic [31:0] ea;
    n  = nbeats(bt, int'(ln));
    ea = a;
    start_req(a, sz, bt, w, ln);
    for (int i = 0; i < n; i++) begin
      check_beat({tag, " R3 beat"}, (i == 0) ? 2'd2 : 2'd3, ea, sz, bt, w);
      if (i == wait_at) begin
        bus_ready = 1'b0;
        @(negedge clk);
        check_beat({tag, " R7 wait hold"}, (i == 0) ? 2'd2 : 2'd3, ea, sz, bt, w);
        bus_ready = 1'b1;
      end
      if (i == stall_at && i < n - 1) begin
        stall_req = 1'b1;
        @(negedge clk);
        ea = bump(ea, sz, bt);
        check_beat({tag, " R8 busy"}, 2'd1, ea, sz, bt, w);
        @(negedge clk);
        check_beat({tag, " R8 busy held"}, 2'd1, ea, sz, bt, w);
        stall_req = 1'b0;
        @(negedge clk);
      end else begin
        @(negedge clk);
        if (i < n - 1) ea = bump(ea, sz, bt);
      end
    end
    chk({tag, " R4 idle after last beat"}, 32'(bus_trans), 32'd0);
  endtask

  task automatic test_reset();
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_size = '0; req_burst = '0;
    req_write = 1'b0; req_len = '0; stall_req = 1'b0; bus_ready = 1'b1; bus_resp = 2'd0;
    repeat (3) @(negedge clk);
    chk("R1 reset trans", 32'(bus_trans), 32'd0);
    chk("R1 reset addr", bus_addr, 32'd0);
    rst_n = 1'b1;
  endtask

  task automatic test_idle_stall();
    @(negedge clk);
    stall_req = 1'b1;
    @(negedge clk);
    chk("R3 idle ignores stall", 32'(bus_trans), 32'd0);
    @(negedge clk);
    chk("R3 idle stays idle", 32'(bus_trans), 32'd0);
    stall_req = 1'b0;
  endtask

  task automatic test_single_stall();
    start_req(32'h0000_0055, 3'd0, 3'd0, 1'b1, 6'd0);
    stall_req = 1'b1;
    check_beat("R2 single nonseq", 2'd2, 32'h0000_0055, 3'd0, 3'd0, 1'b1);
    @(negedge clk);
    chk("R8 no busy after single", 32'(bus_trans), 32'd0);
    stall_req = 1'b0;
  endtask

  task automatic test_error_abort();
    start_req(32'h0000_0400, 3'd2, 3'd5, 1'b1, 6'd0);
    @(negedge clk);
    check_beat("R5 incr8 second beat", 2'd3, 32'h0000_0404, 3'd2, 3'd5, 1'b1);
    bus_resp = 2'd1; bus_ready = 1'b0;
    @(negedge clk);
    chk("R9 idle after error", 32'(bus_trans), 32'd0);
    bus_ready = 1'b1;
    @(negedge clk);
    chk("R9 idle in error second cycle", 32'(bus_trans), 32'd0);
    bus_resp = 2'd0;
    @(negedge clk);
    chk("R9 remaining beats dropped", 32'(bus_trans), 32'd0);
  endtask

  task automatic offer_bad(input string what, input logic [31:0] a, input logic [2:0] sz,
                           input logic [2:0] bt, input logic [5:0] ln);
    @(negedge clk);
    req_addr = a; req_size = sz; req_burst = bt; req_write = 1'b0; req_len = ln;
    req_valid = 1'b1;
    #1;
    chk({"R10 error flag ", what}, 32'(req_error), 32'd1);
    chk({"R10 no accept ", what}, 32'(req_accept), 32'd0);
    @(negedge clk);
    req_valid = 1'b0;
    chk({"R10 bus idle ", what}, 32'(bus_trans), 32'd0);
  endtask

  initial begin
    test_reset();
    test_idle_stall();
    run_burst("single byte", 32'h0000_0055, 3'd0, 3'd0, 1'b1, 6'd0, -1, -1);
    run_burst("R5 incr4 word", 32'h0000_0100, 3'd2, 3'd3, 1'b1, 6'd0, -1, 0);
    run_burst("R6 wrap4 word", 32'h0000_0038, 3'd2, 3'd2, 1'b0, 6'd0, 1, -1);
    run_burst("R6 wrap8 half", 32'h0000_001E, 3'd1, 3'd4, 1'b1, 6'd0, -1, 5);
    run_burst("R6 wrap16 byte", 32'h0000_0807, 3'd0, 3'd6, 1'b0, 6'd0, 14, -1);
    run_burst("R4 open len5", 32'h0000_0200, 3'd1, 3'd1, 1'b1, 6'd5, 2, 3);
    run_burst("R4 open len0", 32'h0000_0300, 3'd2, 3'd1, 1'b0, 6'd0, -1, -1);
    run_burst("R11 incr16 page end", 32'h0000_03C0, 3'd2, 3'd7, 1'b1, 6'd0, 7, -1);
    run_burst("R5 incr8 read", 32'h0000_1010, 3'd1, 3'd5, 1'b0, 6'd0, -1, 7);
    test_single_stall();
    test_error_abort();
    offer_bad("misaligned word", 32'h0000_0102, 3'd2, 3'd0, 6'd0);
    offer_bad("misaligned half", 32'h0000_0101, 3'd1, 3'd3, 6'd0);
    offer_bad("size too big", 32'h0000_0000, 3'd3, 3'd0, 6'd0);
    offer_bad("incr16 crosses page", 32'h0000_03F0, 3'd2, 3'd7, 6'd0);
    offer_bad("open burst crosses page", 32'h0000_03F8, 3'd2, 3'd1, 6'd3);
    run_burst("R2 after rejects", 32'h0000_0010, 3'd2, 3'd0, 1'b0, 6'd0, -1, -1);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #(CLK_P * 50000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected end of run");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule